// File: doc/BRIEF.md
# BCD Alarm Clock Timekeeper

This block keeps the time of day for a board running from a single fast oscillator. It divides the input clock down to a one-cycle time-base tick at either a slow or a fast rate. It also produces two square-wave tones, a high one and a low one. Hours, minutes and seconds are held as packed two-digit BCD values and are presented on three 8-bit outputs, ready for a seven-segment decoder.

Two keys let the user step the minutes or the hours by hand. While a key is held, the chosen field advances on every time-base tick instead of waiting for its carry. A separate alarm time, with its own hour and minute fields, is stepped at the slow rate by two set keys. A mode switch puts the alarm time on the hour and minute outputs.

A single tone output is driven by two sources. The first is an hourly chime during the last seconds before the hour. The second is an alarm that sounds for the whole matching minute, and an enable switch can mute it. Every register runs on the input clock; the slower rates exist only as one-cycle enables.

Top module: `bcd_alarm_clock`

## Requirements
- R1: When rst_ni is low, the time outputs read 00:00:00 and tone_o is low. This happens at once, without waiting for a clock edge.
- R2: Seconds and minutes count 00 to 59 as packed BCD, with the tens digit in bits 7:4. The tens digit advances only when the units digit is 9. On each tick where seconds go from 59 to 00, minutes advance by one.
- R3: Hours count 00 to 23 in BCD and advance on the tick where minutes and seconds leave 59:59. The hour value is never outside 00 to 23, and any illegal value returns to 00 on the next tick.
- R4: With fast_rate_i low, a time-base tick occurs once every CLK_HZ/SLOW_HZ clock cycles. With it high, a tick occurs once every CLK_HZ/FAST_HZ cycles. Either way, the k-th tick falls on the k-times-period rising edge after reset release.
- R5: While adj_min_i is high, minutes advance on every tick, wrapping from 59 to 00. Seconds keep counting.
- R6: While adj_hr_i is high, hours advance on every tick, wrapping from 23 to 00.
- R7: The hourly chime plays only while minutes read 59. It carries the low tone during seconds 51, 53, 55 and 57, and the high tone during second 59. It is silent at all other times.
- R8: The alarm hour (00 to 23) and alarm minute (00 to 59) power up at 00:00. Each advances on every slow-rate tick while its own set key is high, with no carry between the two fields. Reset does not change them.
- R9: While the time's hour and minute equal the alarm setting and alarm_en_i is high, the alarm sounds. It gives the low tone on odd seconds and the high tone on even seconds. When alarm_en_i is low, the alarm is silent.
- R10: While show_alarm_i is high, hr_o and min_o show the alarm setting. sec_o always shows the running seconds.
- R11: The high tone is a 50% square wave with a period of CLK_HZ/TONE_HI_HZ cycles, and the low tone has a period of CLK_HZ/TONE_LO_HZ cycles. Both are low in reset and first rise half a period after release. tone_o is the OR of the chime and the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset of time, dividers and tones |
| adj_min_i | input | 1 | Hold to step minutes every tick |
| adj_hr_i | input | 1 | Hold to step hours every tick |
| show_alarm_i | input | 1 | High: hour/minute outputs show the alarm setting |
| set_alarm_min_i | input | 1 | Hold to step the alarm minute at the slow rate |
| set_alarm_hr_i | input | 1 | Hold to step the alarm hour at the slow rate |
| alarm_en_i | input | 1 | Low mutes the alarm tone |
| fast_rate_i | input | 1 | Time-base select: low slow rate, high fast rate |
| hr_o | output | 8 | Hours (or alarm hours), packed BCD |
| min_o | output | 8 | Minutes (or alarm minutes), packed BCD |
| sec_o | output | 8 | Seconds, packed BCD |
| tone_o | output | 1 | Beeper / LED drive |

## Verification
The bench builds the block with CLK_HZ=40, SLOW_HZ=1, FAST_HZ=5, TONE_HI_HZ=10 and TONE_LO_HZ=5. This gives a fast tick every 8 cycles, a slow tick every 40, and tone periods of 4 and 8 cycles. At these values a full hour of fast-rate counting fits in about 29,000 cycles. That hour crosses every second and minute value, the hour carry, the alarm minute at power-up and the complete chime window. The bench also tests the adjust keys through a 23-to-00 wrap, sets the alarm and jumps the time onto it, and checks the muting, slow-rate timing and reset retention of the alarm. In every cycle it compares all outputs, including the exact tone waveform, against an arithmetic model.

// File: rtl/clock_pkg.sv
package clock_pkg;
  typedef logic [7:0] bcd2_t;

  function automatic bcd2_t next_mod60(bcd2_t v);
    if (v[7:4] > 4'd5 || v[3:0] > 4'd9) return 8'h00;
    if (v[3:0] != 4'd9) return {v[7:4], v[3:0] + 4'd1};
    if (v[7:4] == 4'd5) return 8'h00;
    return {v[7:4] + 4'd1, 4'd0};
  endfunction

  function automatic bcd2_t next_mod24(bcd2_t v);
    if (v[7:4] > 4'd2 || v[3:0] > 4'd9 || (v[7:4] == 4'd2 && v[3:0] >= 4'd3))
      return 8'h00;
    if (v[3:0] != 4'd9) return {v[7:4], v[3:0] + 4'd1};
    return {v[7:4] + 4'd1, 4'd0};
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R4
    end
  endgenerate
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tone_o
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt_q;
  logic         tone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tone_q <= ~tone_q;
    end else begin
      cnt_q  <= cnt_q + W'(1);
    end
  end

  assign tone_o = tone_q;

  generate
    if (HALF > 1) begin : g_chk
      // a toggle is never followed by another on the next edge
      AST_TONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tone_q != $past(tone_q)) |=> $stable(tone_q)); // R11
    end
  endgenerate
endmodule

// File: rtl/bcd_counter.sv
module bcd_counter
  import clock_pkg::*;
#(
  parameter bit MOD24  = 1'b0,
  parameter bit RETAIN = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  output bcd2_t q_o
);
  bcd2_t q, q_next;

  assign q_next = MOD24 ? next_mod24(q) : next_mod60(q);

  generate
    if (RETAIN) begin : g_keep
      // power-up value only; clock reset leaves it alone
      bcd2_t q_r = 8'h00;
      always_ff @(posedge clk_i) begin
        if (en_i) q_r <= q_next;
      end
      assign q = q_r;
    end else begin : g_rst
      bcd2_t q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_r <= 8'h00;
        else if (en_i) q_r <= q_next;
      end
      assign q = q_r;
    end
  endgenerate

  assign q_o = q;

  AST_UNITS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[3:0] <= 4'd9); // R2
  AST_TENS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[7:4] != $past(q[7:4])) |-> ($past(q[3:0]) == 4'd9 || q == 8'h00)); // R2
  AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(q)); // R8
endmodule

// File: rtl/bcd_alarm_clock.sv
module bcd_alarm_clock
  import clock_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SLOW_HZ    = 1,
  parameter int FAST_HZ    = 5,
  parameter int TONE_HI_HZ = 1000,
  parameter int TONE_LO_HZ = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adj_min_i,
  input  logic       adj_hr_i,
  input  logic       show_alarm_i,
  input  logic       set_alarm_min_i,
  input  logic       set_alarm_hr_i,
  input  logic       alarm_en_i,
  input  logic       fast_rate_i,
  output logic [7:0] hr_o,
  output logic [7:0] min_o,
  output logic [7:0] sec_o,
  output logic       tone_o
);
  localparam int SLOW_DIV = CLK_HZ / SLOW_HZ;
  localparam int FAST_DIV = CLK_HZ / FAST_HZ;
  localparam int HI_HALF  = CLK_HZ / (2 * TONE_HI_HZ);
  localparam int LO_HALF  = CLK_HZ / (2 * TONE_LO_HZ);

  logic slow_tick, fast_tick, time_tick;
  logic tone_hi, tone_lo;
  bcd2_t sec_q, min_q, hr_q, al_min_q, al_hr_q;
  logic sec_wrap, min_en, hr_en;
  logic chime, alarm_hit, alarm_tone;

  rate_divider #(.DIV(SLOW_DIV)) u_slow (.clk_i, .rst_ni, .tick_o(slow_tick));
  rate_divider #(.DIV(FAST_DIV)) u_fast (.clk_i, .rst_ni, .tick_o(fast_tick));
  tone_divider #(.HALF(HI_HALF)) u_hi   (.clk_i, .rst_ni, .tone_o(tone_hi));
  tone_divider #(.HALF(LO_HALF)) u_lo   (.clk_i, .rst_ni, .tone_o(tone_lo));

  assign time_tick = fast_rate_i ? fast_tick : slow_tick;
  assign sec_wrap  = (sec_q == 8'h59);
  assign min_en    = time_tick & (adj_min_i | sec_wrap);
  assign hr_en     = time_tick & (adj_hr_i | (sec_wrap & (min_q == 8'h59)));

  bcd_counter #(.MOD24(1'b0), .RETAIN(1'b0)) u_sec (
    .clk_i, .rst_ni, .en_i(time_tick), .q_o(sec_q));
  bcd_counter #(.MOD24(1'b0), .RETAIN(1'b0)) u_min (
    .clk_i, .rst_ni, .en_i(min_en), .q_o(min_q));
  bcd_counter #(.MOD24(1'b1), .RETAIN(1'b0)) u_hr (
    .clk_i, .rst_ni, .en_i(hr_en), .q_o(hr_q));

  bcd_counter #(.MOD24(1'b0), .RETAIN(1'b1)) u_al_min (
    .clk_i, .rst_ni, .en_i(slow_tick & set_alarm_min_i), .q_o(al_min_q));
  bcd_counter #(.MOD24(1'b1), .RETAIN(1'b1)) u_al_hr (
    .clk_i, .rst_ni, .en_i(slow_tick & set_alarm_hr_i), .q_o(al_hr_q));

  always_comb begin
    chime = 1'b0;
    if (min_q == 8'h59) begin
      case (sec_q)
        8'h51, 8'h53, 8'h55, 8'h57: chime = tone_lo;
        8'h59:                      chime = tone_hi;
        default:                    chime = 1'b0;
      endcase
    end
  end

  assign alarm_hit  = (hr_q == al_hr_q) && (min_q == al_min_q);
  // BCD units parity equals second parity
  assign alarm_tone = alarm_en_i & alarm_hit & (sec_q[0] ? tone_lo : tone_hi);

  assign tone_o = chime | alarm_tone;
  assign hr_o   = show_alarm_i ? al_hr_q  : hr_q;
  assign min_o  = show_alarm_i ? al_min_q : min_q;
  assign sec_o  = sec_q;

  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_q <= 8'h23) && (hr_q[3:0] <= 4'd9)); // R3
  AST_MIN_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_min_i && time_tick) |=> (min_q != $past(min_q))); // R5
  AST_HR_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_hr_i && time_tick) |=> (hr_q != $past(hr_q))); // R6
  AST_QUIET_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_q != 8'h59 && !alarm_hit) |-> !tone_o); // R7
  AST_ALARM_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_en_i && min_q != 8'h59) |-> !tone_o); // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!tone_o && sec_o == 8'h00)); // R1
endmodule

// File: tb/bcd_alarm_clock_tb_top.sv
module bcd_alarm_clock_tb_top;
  localparam int CLK_HZ = 40;
  localparam int FAST_P = 8;   // CLK_HZ/5
  localparam int SLOW_P = 40;  // CLK_HZ/1
  localparam int HI_H   = 2;   // half period of high tone
  localparam int LO_H   = 4;   // half period of low tone

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic adj_min_i = 1'b0, adj_hr_i = 1'b0, show_alarm_i = 1'b0;
  logic set_alarm_min_i = 1'b0, set_alarm_hr_i = 1'b0;
  logic alarm_en_i = 1'b1, fast_rate_i = 1'b1;
  logic [7:0] hr_o, min_o, sec_o;
  logic tone_o;

  always #2.5 clk_i = ~clk_i;

  bcd_alarm_clock #(.CLK_HZ(CLK_HZ), .SLOW_HZ(1), .FAST_HZ(5),
                    .TONE_HI_HZ(10), .TONE_LO_HZ(5)) dut_i (
    .clk_i, .rst_ni, .adj_min_i, .adj_hr_i, .show_alarm_i,
    .set_alarm_min_i, .set_alarm_hr_i, .alarm_en_i, .fast_rate_i,
    .hr_o, .min_o, .sec_o, .tone_o);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int h = 0, m = 0, s = 0, ah = 0, am = 0;
  string sec_tag = "R1", min_tag = "R1", hr_tag = "R1", tone_tag = "R1";

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic int exp_tone();
    int lo, hi, ch, al;
    if (!rst_ni) return 0;
    lo = (cyc / LO_H) % 2;
    hi = (cyc / HI_H) % 2;
    ch = 0;
    if (m == 59) begin
      if (s == 51 || s == 53 || s == 55 || s == 57) ch = lo;
      else if (s == 59) ch = hi;
    end
    al = 0;
    if (alarm_en_i && h == ah && m == am) al = (s % 2 == 1) ? lo : hi;
    return ch | al;
  endfunction

  task automatic compare();
    check(hr_tag,  hr_o,  to_bcd(show_alarm_i ? ah : h));
    check(min_tag, min_o, to_bcd(show_alarm_i ? am : m));
    check(sec_tag, sec_o, to_bcd(s));
    check(tone_tag, tone_o, exp_tone());
  endtask

  task automatic step();
    int os, om;
    @(posedge clk_i);
    @(negedge clk_i);
    if (rst_ni) begin
      cyc++;
      if (cyc % (fast_rate_i ? FAST_P : SLOW_P) == 0) begin
        os = s; om = m;
        s = (os + 1) % 60;
        if (adj_min_i || os == 59) m = (om + 1) % 60;
        if (adj_hr_i || (om == 59 && os == 59)) h = (h + 1) % 24;
      end
      if (cyc % SLOW_P == 0) begin
        if (set_alarm_min_i) am = (am + 1) % 60;
        if (set_alarm_hr_i)  ah = (ah + 1) % 24;
      end
    end
    compare();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_tags(string t_s, string t_m, string t_h, string t_t);
    sec_tag = t_s; min_tag = t_m; hr_tag = t_h; tone_tag = t_t;
  endtask

  initial begin
    #20_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state, alarm power-up value R8 via R10 mux
    set_tags("R1", "R1", "R1", "R1");
    steps(3);
    show_alarm_i = 1'b1;
    set_tags("R1", "R8 R10", "R8 R10", "R1");
    #1 compare();
    @(negedge clk_i);
    show_alarm_i = 1'b0;
    rst_ni = 1'b1;
    cyc = 0;

    // one full hour at fast rate: counting, carries, timing, chime, alarm at 00:00
    set_tags("R2 R4", "R2", "R3", "R7 R9 R11");
    steps(3600 * FAST_P + 80);

    // manual adjust through wraps
    adj_min_i = 1'b1;
    set_tags("R2", "R5", "R3", "R7 R9");
    steps(70 * FAST_P);
    adj_min_i = 1'b0;
    adj_hr_i = 1'b1;
    set_tags("R2", "R2", "R6", "R7 R9");
    steps(30 * FAST_P);
    adj_hr_i = 1'b0;

    // set alarm to 01:10, viewed through the mux; align to a slow tick first
    while (cyc % SLOW_P != 0) step();
    show_alarm_i = 1'b1;
    set_alarm_min_i = 1'b1;
    set_tags("R2", "R8 R10", "R8 R10", "R7 R9");
    steps(10 * SLOW_P);
    set_alarm_min_i = 1'b0;
    set_alarm_hr_i = 1'b1;
    steps(25 * SLOW_P);
    set_alarm_hr_i = 1'b0;
    steps(4);
    show_alarm_i = 1'b0;

    // move the time onto the alarm minute
    set_tags("R2", "R5", "R6", "R9");
    for (int k = 0; k < 5 && !(h == ah && m == am); k++) begin
      adj_hr_i = 1'b1;
      for (int i = 0; i < 400 && h != ah; i++) step();
      adj_hr_i = 1'b0;
      adj_min_i = 1'b1;
      for (int i = 0; i < 800 && m != am; i++) step();
      adj_min_i = 1'b0;
    end
    check("R9 match", (h == ah && m == am) ? 1 : 0, 1);
    set_tags("R2", "R2", "R3", "R9 R11");
    steps(40);
    alarm_en_i = 1'b0;
    set_tags("R2", "R2", "R3", "R9 muted");
    steps(40);
    alarm_en_i = 1'b1;
    set_tags("R2", "R2", "R3", "R9");
    steps(16);

    // slow rate
    while (cyc % SLOW_P != 0) step();
    fast_rate_i = 1'b0;
    set_tags("R4", "R2", "R3", "R7 R9");
    steps(3 * SLOW_P + 5);

    // async reset mid-run; alarm setting kept
    @(negedge clk_i);
    rst_ni = 1'b0;
    h = 0; m = 0; s = 0; cyc = 0;
    #1;
    set_tags("R1", "R1", "R1", "R1");
    compare();
    steps(2);
    show_alarm_i = 1'b1;
    set_tags("R1", "R8", "R8", "R1");
    #1 compare();
    check("R8 retained hr", ah, 1);
    check("R8 retained min", am, 10);
    @(negedge clk_i);
    show_alarm_i = 1'b0;
    rst_ni = 1'b1;
    fast_rate_i = 1'b1;
    set_tags("R4", "R2", "R3", "R11");
    steps(3 * FAST_P);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule